// File: doc/BRIEF.md
# Test Data Pattern Generator

This block supplies one test data word per iteration to a register or memory tester. A four-bit mode input picks one of nine patterns: fixed zeroes, fixed ones, a caller-supplied constant, a walking one, a walking zero, pseudo-random words, a sequential count, alternating ones and zeroes, and the constant alternating with its complement. A step strobe advances the pattern to its next value and a restart strobe sends every pattern back to its first value.

The data width is a parameter. A hole mask input flags bit positions that the target does not store. The walking and counting patterns are laid out over the stored positions only, as if the holes were not there. A parameter also sets a number of low-order parity-flag positions. These positions never carry the walking marker or count bits, and they are driven to a fixed level instead. Comparing read-back data is done elsewhere.

Top module: `patgen_top`

## Requirements
- R1: After reset, or in the cycle after a restart strobe, the walking marker sits at the lowest valid position, the count is zero, the alternating phase is at its first value and the random register holds its seed.
- R2: Mode codes are 0 zeroes, 1 ones, 2 constant, 3 walking one, 4 walking zero, 5 random, 6 sequential, 7 ones/zeroes alternation, 8 constant/complement alternation. Codes 9 to 15 drive all zeroes. Modes 0 to 2 do not depend on stepping.
- R3: In mode 3 exactly one valid position is 1. Each step moves it to the next higher valid position. A step taken from the highest valid position returns it to the lowest.
- R4: In mode 4 every valid position is 1 except the marker position, which is 0. The marker moves and wraps as in R3.
- R5: In mode 6 the count starts at zero and rises by one per step. Count bit k is placed on the k-th valid position counted from the least significant end, so the value wraps modulo 2 to the power of the number of valid positions.
- R6: A valid position is one whose hole-mask bit is 0 and that is not a parity-flag position. In modes 3, 4 and 6 every hole position outputs 0 and is skipped by the marker and the count.
- R7: The PAR_BITS least significant positions are parity flags. They output 1 in mode 4 and 0 in modes 3 and 6.
- R8: Mode 7 outputs all ones in the first phase and all zeroes in the second. Mode 8 outputs the constant in the first phase and its bitwise complement in the second. Each step flips the phase.
- R9: Mode 5 output bit i equals bit (i mod 32) of a 32-bit register. On each step the register shifts left and takes in, at bit 0, the XOR of bits 31, 21, 1 and 0. The register starts from the SEED parameter.
- R10: Without a step or restart strobe, all pattern state holds. When restart and step arrive together, restart wins.
- R11: All pattern state advances on every step whatever the selected mode, so switching modes continues each pattern from where its state stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 4 | Pattern select (codes in R2) |
| const_i | input | WIDTH | Constant for modes 2 and 8 |
| hole_i | input | WIDTH | 1 marks a position that is not stored |
| step_i | input | 1 | Advance to the next pattern value |
| restart_i | input | 1 | Return all patterns to their first value |
| data_o | output | WIDTH | Current test data word |

## Verification
The bench builds the block with WIDTH of 40 and PAR_BITS of 2. A width above 32 makes the random register repeat across the upper bits, and two parity flags keep a forced pair at the bottom of every walking and counting word. With a sparse hole mask of eight valid positions, a 300-step count run passes the modulo-256 wrap. A dense mask with 38 valid positions lets a 45-step walk cross its wrap. A mid-run mask change shows the marker folding back when its position becomes invalid.

// File: rtl/patgen_pkg.sv
// Shared definitions for the test data pattern generator.
// Assumes a four-bit mode bus; codes above PM_ALTC select all zeroes.
package patgen_pkg;
    typedef enum logic [3:0] {
        PM_ZERO  = 4'd0,
        PM_ONES  = 4'd1,
        PM_CONST = 4'd2,
        PM_WALK1 = 4'd3,
        PM_WALK0 = 4'd4,
        PM_RAND  = 4'd5,
        PM_SEQ   = 4'd6,
        PM_ALT   = 4'd7,
        PM_ALTC  = 4'd8
    } pat_mode_e;

    localparam int LFSR_W = 32;
endpackage

// File: rtl/patgen_lfsr.sv
// 32-bit maximal-length shift register for the random pattern.
// It shifts left with feedback from bits 31, 21, 1 and 0. SEED must be nonzero.
module patgen_lfsr #(
    parameter logic [31:0] SEED = 32'h1F2E_3D4C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_i,
    input  logic        restart_i,
    output logic [31:0] state_o
);
    logic [31:0] sr;

    // Load the seed on reset or restart and shift once per step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            sr <= SEED;
        else if (step_i)
            sr <= {sr[30:0], sr[31] ^ sr[21] ^ sr[1] ^ sr[0]};
    end

    assign state_o = sr;

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sr != 32'd0);                                                      // R9
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> $stable(sr));                          // R10
endmodule

// File: rtl/patgen_scatter.sv
// Spreads a compact vector over the valid positions of a word.
// Compact bit k lands on the k-th valid position counted from the LSB.
// Invalid positions output 0. The module also counts the valid positions.
module patgen_scatter #(
    parameter int WIDTH = 16,
    localparam int PW = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] valid_i,
    input  logic [WIDTH-1:0] compact_i,
    output logic [WIDTH-1:0] spread_o,
    output logic [PW-1:0]    n_valid_o
);
    // Walk the word from the LSB and hand each valid slot the next compact bit.
    always_comb begin
        logic [PW-1:0] k;
        k        = '0;
        spread_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (valid_i[i]) begin
                spread_o[i] = compact_i[k];
                k           = k + PW'(1);
            end
        end
        n_valid_o = k;
    end
endmodule

// File: rtl/patgen_state.sv
// Iteration state shared by all patterns: the walking marker index over the
// valid positions, the compact count and the alternation phase.
// Every step advances all of them, and restart has priority over step.
module patgen_state #(
    parameter int WIDTH = 16,
    localparam int PW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic [PW-1:0]    n_valid_i,
    output logic [PW-1:0]    pos_o,
    output logic [WIDTH-1:0] cnt_o,
    output logic             phase_o
);
    logic at_top;

    // The marker is at or beyond the last valid slot, so the next step wraps it.
    assign at_top = ({1'b0, pos_o} + (PW+1)'(1)) >= {1'b0, n_valid_i};

    // Move the marker, the count and the phase together.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pos_o   <= '0;
            cnt_o   <= '0;
            phase_o <= 1'b0;
        end else if (step_i) begin
            pos_o   <= at_top ? '0 : pos_o + PW'(1);
            cnt_o   <= cnt_o + WIDTH'(1);
            phase_o <= ~phase_o;
        end
    end

    AST_RESTART_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pos_o == '0 && cnt_o == '0 && !phase_o));           // R1
    AST_WALK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i && at_top) |=> pos_o == '0);                 // R3
    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !restart_i) |=> ($stable(pos_o) && $stable(cnt_o)
                                     && $stable(phase_o)));                // R10
    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !restart_i) |=> phase_o != $past(phase_o));             // R8
endmodule

// File: rtl/patgen_top.sv
// Test data pattern generator: one word per iteration, selected by mode.
// The PAR_BITS least significant positions are parity flags with forced
// levels in the walking and counting modes. Holes are skipped by those modes.
// Assumes PAR_BITS < WIDTH.
module patgen_top #(
    parameter int          WIDTH    = 16,
    parameter int          PAR_BITS = 2,
    parameter logic [31:0] SEED     = 32'h1F2E_3D4C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic [WIDTH-1:0] const_i,
    input  logic [WIDTH-1:0] hole_i,
    input  logic             step_i,
    input  logic             restart_i,
    output logic [WIDTH-1:0] data_o
);
    import patgen_pkg::*;

    localparam int PW = $clog2(WIDTH + 1);
    localparam logic [WIDTH-1:0] PAR_MASK = (WIDTH'(1) << PAR_BITS) - WIDTH'(1);
    localparam logic [WIDTH-1:0] ONE_HOT0 = WIDTH'(1);

    pat_mode_e        mode;
    logic [PW-1:0]    pos, n_valid;
    logic [WIDTH-1:0] cnt, valid, onehot, compact, spread, rnd;
    logic             phase;
    logic [31:0]      lfsr;

    assign mode   = pat_mode_e'(mode_i);
    assign valid  = ~hole_i & ~PAR_MASK;
    assign onehot = ONE_HOT0 << pos;

    // Choose the compact form that is spread over the valid positions.
    always_comb begin
        case (mode)
            PM_WALK1: compact = onehot;
            PM_WALK0: compact = ~onehot;
            default:  compact = cnt;
        endcase
    end

    patgen_state #(.WIDTH(WIDTH)) u_state (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .restart_i(restart_i),
        .n_valid_i(n_valid), .pos_o(pos), .cnt_o(cnt), .phase_o(phase)
    );

    patgen_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .restart_i(restart_i),
        .state_o(lfsr)
    );

    patgen_scatter #(.WIDTH(WIDTH)) u_scatter (
        .valid_i(valid), .compact_i(compact), .spread_o(spread),
        .n_valid_o(n_valid)
    );

    // Repeat the 32-bit random register across the full width.
    for (genvar g = 0; g < WIDTH; g++) begin : g_rep
        assign rnd[g] = lfsr[g % LFSR_W];
    end

    // Output selection by mode.
    always_comb begin
        case (mode)
            PM_ZERO:  data_o = '0;
            PM_ONES:  data_o = '1;
            PM_CONST: data_o = const_i;
            PM_WALK1: data_o = spread;
            PM_WALK0: data_o = spread | PAR_MASK;
            PM_RAND:  data_o = rnd;
            PM_SEQ:   data_o = spread;
            PM_ALT:   data_o = phase ? '0 : '1;
            PM_ALTC:  data_o = phase ? ~const_i : const_i;
            default:  data_o = '0;
        endcase
    end

    AST_HOLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'd3 || mode_i == 4'd4 || mode_i == 4'd6)
            |-> (data_o & hole_i & ~PAR_MASK) == '0);                       // R6
    AST_PARITY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'd3 || mode_i == 4'd6) |-> (data_o & PAR_MASK) == '0);  // R7
    AST_PARITY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'd4) |-> (data_o & PAR_MASK) == PAR_MASK);              // R7
    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'd3) |-> $countones(data_o) <= 1);                      // R3
    AST_FIXED_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 4'd2) |-> data_o == const_i);                            // R2
endmodule

// File: tb/patgen_top_test.sv
// Bench: a behavioural reference model, compared with the output every clock.
module patgen_top_test;
    localparam int          W    = 40;
    localparam int          PB   = 2;
    localparam logic [31:0] SEED = 32'h1F2E_3D4C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mode = 4'd3;
    logic [W-1:0] cst = 40'hA5_5A0F_F0C3;
    logic [W-1:0] hole = '0;
    logic         step = 1'b0;
    logic         restart = 1'b0;
    logic [W-1:0] data;

    always #10 clk = ~clk;

    patgen_top #(.WIDTH(W), .PAR_BITS(PB), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .const_i(cst),
        .hole_i(hole), .step_i(step), .restart_i(restart), .data_o(data)
    );

    int           m_pos;
    logic [W-1:0] m_cnt;
    logic         m_ph;
    logic [31:0]  m_lfsr;
    int           n_chk = 0;
    int           n_err = 0;

    function automatic logic [W-1:0] valid_bits();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = !hole[i] && (i >= PB);
        return v;
    endfunction

    function automatic logic [W-1:0] model_out();
        logic [W-1:0] v, r;
        int k;
        v = valid_bits();
        r = '0;
        k = 0;
        case (mode)
            4'd1: r = '1;
            4'd2: r = cst;
            4'd3, 4'd4, 4'd6: begin
                for (int i = 0; i < W; i++) begin
                    if (i < PB && mode == 4'd4) r[i] = 1'b1;
                    if (v[i]) begin
                        if (mode == 4'd3)      r[i] = (k == m_pos);
                        else if (mode == 4'd4) r[i] = (k != m_pos);
                        else                   r[i] = m_cnt[k];
                        k++;
                    end
                end
            end
            4'd5: for (int i = 0; i < W; i++) r[i] = m_lfsr[i % 32];
            4'd7: r = m_ph ? '0 : '1;
            4'd8: r = m_ph ? ~cst : cst;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_home();
        m_pos = 0; m_cnt = '0; m_ph = 1'b0; m_lfsr = SEED;
    endtask

    task automatic model_advance();
        int nv;
        nv = $countones(valid_bits());
        if (restart || !rst_n) begin
            model_home();
        end else if (step) begin
            if (m_pos + 1 >= nv) m_pos = 0; else m_pos++;
            m_cnt  = m_cnt + 1'b1;
            m_ph   = ~m_ph;
            m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
        end
    endtask

    // Drive strobes for n cycles, check the output each cycle, then follow the edge.
    task automatic run(int n, logic st, logic rs, string tag);
        logic [W-1:0] exp;
        for (int c = 0; c < n; c++) begin
            step = st; restart = rs;
            #1;
            exp = model_out();
            n_chk++;
            if (data !== exp) begin
                n_err++;
                $display("FAIL %s: mode %0d got %h expected %h", tag, mode, data, exp);
            end
            @(posedge clk);
            model_advance();
            @(negedge clk);
        end
        step = 1'b0; restart = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        model_home();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: home state after reset
        mode = 4'd3; run(1, 0, 0, "R1 walk home");
        mode = 4'd5; run(1, 0, 0, "R1 seed");
        // R2: fixed and unused codes
        mode = 4'd0;  run(2, 1, 0, "R2 zero");
        mode = 4'd1;  run(2, 1, 0, "R2 ones");
        mode = 4'd2;  run(2, 1, 0, "R2 const");
        mode = 4'd12; run(1, 0, 0, "R2 unused");
        mode = 4'd15; run(1, 0, 0, "R2 unused");
        // R3: walking one over 38 valid bits, through the wrap
        run(1, 0, 1, "R1 restart");
        mode = 4'd3; hole = '0; run(45, 1, 0, "R3");
        // R4, R6 and R7: walking zero with holes and parity flags
        run(1, 0, 1, "R1 restart");
        mode = 4'd4; hole = 40'h00F0_0000_FF00; run(40, 1, 0, "R4");
        run(5, 1, 0, "R6"); run(3, 1, 0, "R7");
        // R6: the mask shrinks while the marker sits high
        hole = ~40'h0000_0000_F0F0; run(12, 1, 0, "R6 shrink");
        // R10: hold, and restart beating step
        run(5, 0, 0, "R10 hold");
        run(1, 1, 1, "R10 both");
        run(1, 0, 0, "R10 after both");
        // R5: count over 8 valid bits, past the wrap
        mode = 4'd6; run(300, 1, 0, "R5");
        mode = 4'd3; run(20, 1, 0, "R6 sparse walk");
        // R9: random words above 32 bits wide
        mode = 4'd5; run(50, 1, 0, "R9");
        // R8: both alternations
        mode = 4'd7; run(4, 1, 0, "R8 alt");
        mode = 4'd8; run(4, 1, 0, "R8 altc");
        // R11: a mode switch continues the shared state
        mode = 4'd6; hole = '0; run(3, 1, 0, "R11");
        mode = 4'd4; run(3, 1, 0, "R11 walk0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule